// File: doc/BRIEF.md
# Checkpointed Register File with Gated Store Buffer

This block gives translated code blocks a hardware checkpoint they can fall back to. It holds a small set of guest registers with a shadow copy beside them. It also holds a gated buffer that keeps every memory write issued inside the current translation block away from memory. When the next block is entered, the control logic pulses `commit`. The working registers are then copied into the shadow set in one cycle, and the held stores are sent to the memory write port one per cycle, oldest first. When a fault is found, the control logic pulses `trap`. The working registers are then reloaded from the shadow set and the held stores are thrown away, so that an interpreter can rebuild precise state from the last checkpoint.

Loads look up the buffer. If they hit, they receive the data of the youngest held store to the same address. The buffer has a fixed depth. A store that finds it full is refused and raises `overflow`, which tells the translator that the block is too large.

The controller has two named states. RUN is the normal state: stores are accepted, and commit or trap act at once. DRAIN is the state in which committed stores are written out: `busy` is high and new stores are refused. The transitions are:
- RUN→DRAIN on a commit without a trap while the buffer holds at least one store.
- RUN→RUN on every other cycle.
- DRAIN→DRAIN while older entries remain.
- DRAIN→RUN in the cycle that writes the last entry.

Top module: `ckpt_unit`

## Requirements
- R1: After reset, all working and shadow registers read zero, the buffer is empty, and `busy`, `mem_we`, `st_accept`, `overflow` and `ld_hit` are low.
- R2: A register write with `reg_we` high updates the working register `reg_waddr`. `reg_rdata` shows the working register `reg_raddr` combinationally.
- R3: A commit without a trap copies every working register into the shadow set. The copy takes the values held before that clock edge, and a register write in the same cycle reaches only the working set.
- R4: A trap reloads every working register from the shadow set. A register write in the same cycle is dropped.
- R5: A store accepted in RUN (`st_accept` high) does not reach the memory port before a commit.
- R6: After a commit in RUN with N>0 held stores, `mem_we` and `busy` are high for exactly the N cycles that follow. The stores appear on `mem_addr`/`mem_data` in the order they were accepted.
- R7: A trap in RUN discards all held stores. A later commit then drains nothing.
- R8: A store offered in RUN while 8 stores are held is refused: `overflow` is high and `st_accept` is low in that cycle.
- R9: A store offered during DRAIN, or in the same cycle as a commit or a trap, is refused with `overflow` low.
- R10: `ld_hit` is high when `ld_addr` equals the address of a held store that is not yet written out. `ld_data` is then the data of the youngest such store.
- R11: When commit and trap are high in the same cycle, the trap wins: the registers are restored, the stores are discarded, and no drain starts.
- R12: A commit with an empty buffer copies the registers and leaves `busy` low.
- R13: A trap during DRAIN restores the registers, but the committed stores still drain to the end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Working register write enable |
| reg_waddr | input | 4 | Register write index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read index |
| reg_rdata | output | 32 | Working register read data |
| commit | input | 1 | Block boundary: checkpoint and release stores |
| trap | input | 1 | Fault: roll back and discard stores |
| st_valid | input | 1 | Store offered |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_accept | output | 1 | Store taken into the buffer this cycle |
| overflow | output | 1 | Store refused because the buffer is full |
| ld_addr | input | 32 | Load address to check against the buffer |
| ld_hit | output | 1 | A held store matches `ld_addr` |
| ld_data | output | 32 | Data of the youngest matching store |
| busy | output | 1 | Drain in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write address |
| mem_data | output | 32 | Memory write data |

## Verification
Commit and trap can fall in the same cycle, and the trap must win. The bench raises both together while stores are held and a register write is pending. The reference model then expects restored registers, an empty buffer and no drain cycles. Register writes are also stacked on commit and trap edges, and a trap is raised mid-drain. The model is compared on every clock, which judges which action took effect at each edge.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_DRAIN = 1'b1
    } ckpt_state_e;
endpackage

// File: rtl/ckpt_regfile.sv
module ckpt_regfile #(
    parameter int NREGS = 16,
    parameter int DW    = 32,
    localparam int RIW  = $clog2(NREGS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [RIW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic [RIW-1:0] raddr,
    output logic [DW-1:0]  rdata,
    input  logic           save,
    input  logic           restore
);
    logic [DW-1:0] work [NREGS];
    logic [DW-1:0] shad [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                work[g] <= '0;
                shad[g] <= '0;
            end else if (restore) begin
                work[g] <= shad[g];
            end else begin
                if (save)
                    shad[g] <= work[g];
                if (we && waddr == RIW'(g))
                    work[g] <= wdata;
            end
        end
    end

    assign rdata = work[raddr];
endmodule

// File: rtl/ckpt_store_buf.sv
module ckpt_store_buf #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          clear,
    input  logic          adv,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          full,
    output logic          empty,
    output logic          last,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data
);
    logic [AW-1:0] a_q [DEPTH];
    logic [DW-1:0] d_q [DEPTH];
    logic [CW-1:0] cnt;
    logic [PW-1:0] rd;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
            rd  <= '0;
        end else begin
            if (push) begin
                a_q[cnt[PW-1:0]] <= push_addr;
                d_q[cnt[PW-1:0]] <= push_data;
                cnt <= cnt + CW'(1);
            end
            if (adv)
                rd <= rd + PW'(1);
        end
    end

    assign full      = (cnt == CW'(DEPTH));
    assign empty     = (cnt == '0);
    assign last      = (CW'(rd) == cnt - CW'(1));
    assign head_addr = a_q[rd];
    assign head_data = d_q[rd];

    // ascending scan: the highest matching index (youngest store) wins
    always_comb begin
        ld_hit  = 1'b0;
        ld_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) >= CW'(rd) && CW'(i) < cnt && a_q[i] == ld_addr) begin
                ld_hit  = 1'b1;
                ld_data = d_q[i];
            end
        end
    end
endmodule

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl
    import ckpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    input  logic trap,
    input  logic st_valid,
    input  logic buf_full,
    input  logic buf_empty,
    input  logic buf_last,
    output logic save,
    output logic restore,
    output logic push,
    output logic overflow,
    output logic buf_clear,
    output logic drain_adv,
    output logic busy,
    output logic mem_we
);
    ckpt_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_RUN;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx  = state;
        save      = commit && !trap;
        restore   = trap;
        push      = 1'b0;
        overflow  = 1'b0;
        buf_clear = 1'b0;
        drain_adv = 1'b0;
        busy      = 1'b0;
        mem_we    = 1'b0;
        unique case (state)
            ST_RUN: begin
                push      = st_valid && !buf_full && !commit && !trap;
                overflow  = st_valid && buf_full && !commit && !trap;
                buf_clear = trap;
                if (commit && !trap && !buf_empty)
                    state_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                busy      = 1'b1;
                mem_we    = 1'b1;
                buf_clear = buf_last;
                drain_adv = !buf_last;
                if (buf_last)
                    state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end
endmodule

// File: rtl/ckpt_unit.sv
module ckpt_unit #(
    parameter int NREGS = 16,
    parameter int DW    = 32,
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int RIW  = $clog2(NREGS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RIW-1:0] reg_waddr,
    input  logic [DW-1:0]  reg_wdata,
    input  logic [RIW-1:0] reg_raddr,
    output logic [DW-1:0]  reg_rdata,
    input  logic           commit,
    input  logic           trap,
    input  logic           st_valid,
    input  logic [AW-1:0]  st_addr,
    input  logic [DW-1:0]  st_data,
    output logic           st_accept,
    output logic           overflow,
    input  logic [AW-1:0]  ld_addr,
    output logic           ld_hit,
    output logic [DW-1:0]  ld_data,
    output logic           busy,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_data
);
    logic save, restore, push, buf_clear, drain_adv;
    logic buf_full, buf_empty, buf_last;

    ckpt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .trap      (trap),
        .st_valid  (st_valid),
        .buf_full  (buf_full),
        .buf_empty (buf_empty),
        .buf_last  (buf_last),
        .save      (save),
        .restore   (restore),
        .push      (push),
        .overflow  (overflow),
        .buf_clear (buf_clear),
        .drain_adv (drain_adv),
        .busy      (busy),
        .mem_we    (mem_we)
    );

    ckpt_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .waddr   (reg_waddr),
        .wdata   (reg_wdata),
        .raddr   (reg_raddr),
        .rdata   (reg_rdata),
        .save    (save),
        .restore (restore)
    );

    ckpt_store_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .clear     (buf_clear),
        .adv       (drain_adv),
        .head_addr (mem_addr),
        .head_data (mem_data),
        .full      (buf_full),
        .empty     (buf_empty),
        .last      (buf_last),
        .ld_addr   (ld_addr),
        .ld_hit    (ld_hit),
        .ld_data   (ld_data)
    );

    assign st_accept = push;
endmodule

// File: rtl/ckpt_unit_chk.sv
module ckpt_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic commit,
    input logic trap,
    input logic st_accept,
    input logic overflow,
    input logic busy,
    input logic mem_we
);
    // R8: a refused store is never also taken
    a_r8_ovf_excl: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> !st_accept);

    // R9: nothing is taken or flagged while draining
    a_r9_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!st_accept && !overflow));

    // R6: a drain only begins after a commit that was not overridden
    a_r6_drain_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(commit && !trap));

    // R5: an accepted store is not written out in the next cycle
    a_r5_held: assert property (@(posedge clk) disable iff (!rst_n)
        st_accept |=> !mem_we);

    // R11: a trap while running never starts a drain
    a_r11_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && !busy) |=> !busy);
endmodule

bind ckpt_unit ckpt_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .trap      (trap),
    .st_accept (st_accept),
    .overflow  (overflow),
    .busy      (busy),
    .mem_we    (mem_we)
);

// File: tb/sim_ckpt_unit.sv
`timescale 1ns/1ps
module sim_ckpt_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        commit = 1'b0, trap = 1'b0, st_valid = 1'b0;
    logic [31:0] st_addr = '0, st_data = '0, ld_addr = '0;
    logic        st_accept, overflow, ld_hit, busy, mem_we;
    logic [31:0] ld_data, mem_addr, mem_data;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ckpt_unit u0 (.*);

    // behavioural reference
    logic [31:0] mreg [16];
    logic [31:0] msh  [16];
    logic [31:0] qa [$];
    logic [31:0] qd [$];
    bit mdrain = 0;
    int mrd = 0;
    int rsel = 0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        bit e_acc, e_ovf, e_hit;
        logic [31:0] e_ld;
        reg_raddr = 4'(rsel);
        rsel = (rsel + 5) % 16;
        @(negedge clk);
        e_acc = st_valid && !mdrain && qa.size() < 8 && !commit && !trap;
        e_ovf = st_valid && !mdrain && qa.size() == 8 && !commit && !trap;
        e_hit = 0;
        e_ld = '0;
        for (int i = qa.size() - 1; i >= mrd; i--)
            if (!e_hit && qa[i] == ld_addr) begin
                e_hit = 1;
                e_ld = qd[i];
            end
        chk(reg_rdata === mreg[reg_raddr], "R2 R3 R4 reg read", reg_rdata, mreg[reg_raddr]);
        chk(st_accept === e_acc, "R5 R9 st_accept", 32'(st_accept), 32'(e_acc));
        chk(overflow === e_ovf, "R8 R9 overflow", 32'(overflow), 32'(e_ovf));
        chk(busy === mdrain, "R6 R11 R12 busy", 32'(busy), 32'(mdrain));
        chk(mem_we === mdrain, "R5 R6 R7 mem_we", 32'(mem_we), 32'(mdrain));
        if (mdrain) begin
            chk(mem_addr === qa[mrd], "R6 R13 mem_addr order", mem_addr, qa[mrd]);
            chk(mem_data === qd[mrd], "R6 R13 mem_data order", mem_data, qd[mrd]);
        end
        chk(ld_hit === e_hit, "R10 ld_hit", 32'(ld_hit), 32'(e_hit));
        if (e_hit)
            chk(ld_data === e_ld, "R10 ld_data youngest", ld_data, e_ld);
        @(posedge clk);
        if (trap) begin
            for (int r = 0; r < 16; r++) mreg[r] = msh[r];
        end else begin
            if (commit) for (int r = 0; r < 16; r++) msh[r] = mreg[r];
            if (reg_we) mreg[reg_waddr] = reg_wdata;
        end
        if (!mdrain) begin
            if (trap) begin
                qa.delete();
                qd.delete();
            end else begin
                if (e_acc) begin
                    qa.push_back(st_addr);
                    qd.push_back(st_data);
                end
                if (commit && qa.size() > 0) begin
                    mdrain = 1;
                    mrd = 0;
                end
            end
        end else begin
            if (mrd == qa.size() - 1) begin
                qa.delete();
                qd.delete();
                mdrain = 0;
                mrd = 0;
            end else mrd++;
        end
        #1;
        reg_we = 0; st_valid = 0; commit = 0; trap = 0;
    endtask

    task automatic wr(input int r, input logic [31:0] v);
        reg_we = 1; reg_waddr = 4'(r); reg_wdata = v; cyc();
    endtask
    task automatic st(input logic [31:0] a, input logic [31:0] d);
        st_valid = 1; st_addr = a; st_data = d; cyc();
    endtask
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 16; r++) begin mreg[r] = '0; msh[r] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !mem_we && !st_accept && !overflow && !ld_hit, "R1 reset outputs",
            {27'd0, busy, mem_we, st_accept, overflow, ld_hit}, 32'd0);
        @(posedge clk); #1;
        idle(16);                                   // R1 all registers read zero
        for (int r = 0; r < 16; r++) wr(r, 32'h1000 + 32'(r));   // R2
        commit = 1; cyc();                          // R12 commit, empty buffer
        wr(1, 32'hDEAD0001);
        wr(2, 32'hDEAD0002);
        trap = 1; cyc();                            // R4 restore
        idle(16);
        // R5 R10: held stores with repeated address
        st(32'h100, 32'hA); st(32'h104, 32'hB); st(32'h100, 32'hC);
        ld_addr = 32'h100; idle(2);
        ld_addr = 32'h108; idle(2);
        ld_addr = 32'h104;
        // R3: commit with same-cycle register write
        commit = 1; reg_we = 1; reg_waddr = 4'd3; reg_wdata = 32'h33; cyc();
        st(32'h200, 32'h1);                         // R9 refused during drain
        idle(4);
        trap = 1; cyc();                            // shadow shows value before write
        idle(16);
        // R8: fill then overflow
        for (int k = 0; k < 8; k++) st(32'h300 + 32'(4 * k), 32'h50 + 32'(k));
        ld_addr = 32'h30C;
        st(32'h400, 32'h99); st(32'h404, 32'h98);
        // R7: trap discards
        trap = 1; cyc();
        commit = 1; cyc();
        idle(3);
        // R9 store with commit in same cycle
        st(32'h500, 32'h5);
        commit = 1; st_valid = 1; st_addr = 32'h504; st_data = 32'h6; cyc();
        idle(3);
        // R11: commit and trap together with stores and write pending
        st(32'h600, 32'h7); st(32'h604, 32'h8);
        wr(5, 32'h55);
        commit = 1; trap = 1; reg_we = 1; reg_waddr = 4'd6; reg_wdata = 32'h66; cyc();
        idle(4);
        commit = 1; cyc();
        idle(16);
        // R13: trap mid-drain
        wr(7, 32'h77);
        commit = 1; cyc();
        st(32'h700, 32'hA1); st(32'h704, 32'hA2); st(32'h708, 32'hA3);
        wr(8, 32'h88);
        commit = 1; cyc();
        wr(9, 32'h99);
        trap = 1; cyc();
        idle(20);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule